// File: doc/BRIEF.md
# Haptic Driver Register Interface over I2C

This block is a two-wire serial target, clocked by the system clock, that fronts a small register bank for a vibration driver. The bus controller addresses the block with its 7-bit target address and a direction bit. It then either loads an 8-bit register pointer and streams data bytes into consecutive registers, or streams bytes out from the current pointer. SCL and SDA are oversampled through two-flop synchronizers. The block pulls SDA low through an open-drain enable and never drives it high.

The bank holds these registers:
- a read-only identity register;
- a control register that carries a self-clearing soft-reset bit, a standby flag and a 3-bit operating-mode field;
- a direct-drive value register;
- a row of effect-queue slots;
- a one-bit launch register.

The mode, standby and launch state are brought out as ports. In direct-drive mode, with standby clear, the drive-value register is passed straight to the output.

Top module: `hap_regif_top`

## Requirements
- R1: The block acknowledges only its own 7-bit address (parameter, default 0x5A). On any other address it leaves SDA released during the acknowledge bit and ignores the rest of the frame, which therefore writes nothing.
- R2: A write frame has this shape: start, address with R/W=0, pointer byte, data bytes, stop. The block acknowledges the address byte, the pointer byte and every data byte by pulling SDA low in the ninth bit.
- R3: In a multi-byte write, the first data byte goes to the pointer and each following byte goes to the next address up.
- R4: A read (R/W=1) returns the byte at the current pointer and advances the pointer after every byte sent. It continues while the controller acknowledges and ends at the first not-acknowledge. A later read with no new pointer resumes where the last one stopped.
- R5: Address 0x00 reads 0xE0. Bits 7:5 hold the device identity 7 and the other bits are 0. Writes to it are acknowledged and have no effect.
- R6: Address 0x01 is the control register. Its layout is bit 7 soft reset, bit 6 standby and bits 2:0 mode; bits 5:3 read 0. It resets to 0x40. standby_o and mode_o show bit 6 and bits 2:0.
- R7: Writing 0x01 with bit 7 set returns every register to its reset value on the next clock, exactly as reset does, whatever the other bits hold. Bit 7 always reads 0.
- R8: With standby set, every register can still be read and written. Standby changes only when the control register is written.
- R9: Address 0x02 is the drive value (reset 0x00). drive_o equals it when mode is 5 and standby is 0; otherwise drive_o is 0x00.
- R10: Addresses 0x04 to 0x0B are eight 8-bit effect slots (reset 0x00) that read back what was written. Address 0x0C holds the launch bit in bit 0: it drives go_o, and its upper bits read 0.
- R11: Any other address (0x03, 0x0D to 0xFF) is acknowledged. Writes to it are discarded and reads return 0x00.
- R12: A start condition at any point restarts frame reception at the address byte. A stop condition at any point returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| mode_o | output | 3 | Operating-mode field |
| standby_o | output | 1 | Standby flag |
| drive_o | output | 8 | Direct drive value, gated by mode and standby |
| go_o | output | 1 | Launch bit |

## Verification
The hardest cases to reach are the ones where the bus protocol and the register side effects meet in a single frame. One is a soft reset written partway through a stream. Another is a frame cut short by a repeated start after only a few address bits. A third is a read that resumes from a pointer left behind by an earlier read. The stimulus builds these from bit-level controller tasks: a multi-byte write that crosses the control register, a deliberate start after four address bits followed by a valid write, and a pointer-less read issued straight after a burst read. Each is checked against a register model kept in the bench.

// File: rtl/hap_regif_pkg.sv
package hap_regif_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WDAT, ST_ACK, ST_TX, ST_MACK
  } i2c_state_e;

  localparam logic [7:0] A_ID    = 8'h00;
  localparam logic [7:0] A_CTRL  = 8'h01;
  localparam logic [7:0] A_DRIVE = 8'h02;

  localparam logic [2:0] DEV_ID      = 3'd7;
  localparam logic [7:0] CTRL_RST    = 8'h40;
  localparam logic [7:0] CTRL_MASK   = 8'h47;
  localparam logic [2:0] MODE_DIRECT = 3'd5;
endpackage

// File: rtl/hap_line_sync.sv
module hap_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/hap_i2c_fsm.sv
module hap_i2c_fsm
  import hap_regif_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  i2c_state_e state_q, nxt_q;
  logic [2:0] bit_cnt_q;
  logic       full_q, nack_q;
  logic [7:0] rx_q, tx_q, ptr_q;
  logic       rx_state;

  assign rx_state = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WDAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      bit_cnt_q <= '0;
      full_q    <= 1'b0;
      nack_q    <= 1'b0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      full_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      full_q  <= 1'b0;
    end else begin
      if (rx_state) begin
        if (scl_rise_i) begin
          rx_q      <= {rx_q[6:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) full_q <= 1'b1;
        end else if (scl_fall_i && full_q) begin
          full_q <= 1'b0;
          case (state_q)
            ST_ADDR: begin
              if (rx_q[7:1] == DEV_ADDR) begin
                state_q <= ST_ACK;
                nxt_q   <= rx_q[0] ? ST_TX : ST_PTR;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_PTR: begin
              ptr_q   <= rx_q;
              state_q <= ST_ACK;
              nxt_q   <= ST_WDAT;
            end
            default: begin
              ptr_q   <= ptr_q + 8'd1;
              state_q <= ST_ACK;
              nxt_q   <= ST_WDAT;
            end
          endcase
        end
      end else begin
        case (state_q)
          ST_ACK: if (scl_fall_i) begin
            bit_cnt_q <= '0;
            state_q   <= nxt_q;
            if (nxt_q == ST_TX) begin
              tx_q  <= rd_data_i;
              ptr_q <= ptr_q + 8'd1;
            end
          end
          ST_TX: if (scl_fall_i) begin
            tx_q      <= {tx_q[6:0], 1'b0};
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) state_q <= ST_MACK;
          end
          ST_MACK: begin
            if (scl_rise_i) nack_q <= sda_i;
            if (scl_fall_i) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                tx_q      <= rd_data_i;
                ptr_q     <= ptr_q + 8'd1;
                bit_cnt_q <= '0;
                state_q   <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_data_o = rx_q;
  assign wr_en_o   = (state_q == ST_WDAT) && scl_fall_i && full_q && !start_i && !stop_i;
  assign sda_oe_o  = (state_q == ST_ACK) || ((state_q == ST_TX) && !tx_q[7]);

  a_r12_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> state_q == ST_ADDR);
  a_r12_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> state_q == ST_IDLE);
  a_r1_foreign_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && scl_fall_i && full_q && !start_i && !stop_i
     && rx_q[7:1] != DEV_ADDR) |=> state_q == ST_IDLE);
  a_r3_ptr_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> ptr_q == $past(ptr_q) + 8'd1);
endmodule

// File: rtl/hap_reg_bank.sv
module hap_reg_bank
  import hap_regif_pkg::*;
#(
  parameter int         NUM_SLOTS = 8,
  parameter logic [7:0] SLOT_BASE = 8'h04
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] ctrl_o,
  output logic [7:0] drive_o,
  output logic       go_o
);
  localparam logic [7:0] GoAddr = SLOT_BASE + 8'(NUM_SLOTS);

  logic [7:0] ctrl_q, drive_q;
  logic       go_q;
  logic [7:0] slot_q [NUM_SLOTS];
  logic       soft_rst;

  assign soft_rst = wr_en_i && (addr_i == A_CTRL) && wr_data_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      drive_q <= '0;
      go_q    <= 1'b0;
    end else if (soft_rst) begin
      ctrl_q  <= CTRL_RST;
      drive_q <= '0;
      go_q    <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL)  ctrl_q  <= wr_data_i & CTRL_MASK;
      if (addr_i == A_DRIVE) drive_q <= wr_data_i;
      if (addr_i == GoAddr)  go_q    <= wr_data_i[0];
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       slot_q[i] <= '0;
      else if (soft_rst)                                 slot_q[i] <= '0;
      else if (wr_en_i && addr_i == SLOT_BASE + 8'(i))   slot_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == A_ID)         rd_data_o = {DEV_ID, 5'b0};
    else if (addr_i == A_CTRL)  rd_data_o = ctrl_q;
    else if (addr_i == A_DRIVE) rd_data_o = drive_q;
    else if (addr_i == GoAddr)  rd_data_o = {7'b0, go_q};
    for (int i = 0; i < NUM_SLOTS; i++)
      if (addr_i == SLOT_BASE + 8'(i)) rd_data_o = slot_q[i];
  end

  assign ctrl_o  = ctrl_q;
  assign drive_o = drive_q;
  assign go_o    = go_q;

  a_r7_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (ctrl_q == CTRL_RST) && (drive_q == 8'h00) && !go_q && (slot_q[0] == 8'h00));
  a_r8_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_CTRL) |=> $stable(ctrl_q));
  a_r10_slot_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == SLOT_BASE) |=> slot_q[0] == $past(wr_data_i));
endmodule

// File: rtl/hap_regif_top.sv
module hap_regif_top
  import hap_regif_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h5A,
  parameter int         NUM_SLOTS = 8,
  parameter logic [7:0] SLOT_BASE = 8'h04
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [2:0] mode_o,
  output logic       standby_o,
  output logic [7:0] drive_o,
  output logic       go_o
);
  logic       sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [7:0] ptr, wr_data, rd_data, ctrl, drive_val;
  logic       wr_en;

  hap_line_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  hap_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop), .rd_data_i(rd_data),
    .ptr_o(ptr), .wr_en_o(wr_en), .wr_data_o(wr_data), .sda_oe_o
  );

  hap_reg_bank #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BASE(SLOT_BASE)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .addr_i(ptr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ctrl_o(ctrl), .drive_o(drive_val), .go_o
  );

  assign mode_o    = ctrl[2:0];
  assign standby_o = ctrl[6];
  assign drive_o   = (ctrl[2:0] == MODE_DIRECT && !ctrl[6]) ? drive_val : 8'h00;

  a_r9_drive_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o != 8'h00) |-> (mode_o == MODE_DIRECT) && !standby_o);
endmodule

// File: tb/hap_regif_top_tb.sv
module hap_regif_top_tb;
  localparam int        CLK_NS = 8;
  localparam int        Q      = 10 * CLK_NS;
  localparam bit [6:0]  DEV    = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, standby, go;
  logic [2:0] mode;
  logic [7:0] drive;
  wire  sda_line = sda_m & ~sda_oe;

  always #(CLK_NS/2) clk = ~clk;

  hap_regif_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .mode_o(mode), .standby_o(standby), .drive_o(drive), .go_o(go)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model
  logic [7:0] m_ctrl = 8'h40, m_drive = 8'h00, m_go = 8'h00;
  logic [7:0] m_slot [8];

  // scoreboard queues
  logic [7:0] exp_q[$], act_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return 8'hE0;
    if (a == 8'h01) return m_ctrl;
    if (a == 8'h02) return m_drive;
    if (a >= 8'h04 && a <= 8'h0B) return m_slot[a - 8'h04];
    if (a == 8'h0C) return m_go;
    return 8'h00;
  endfunction

  task automatic m_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h01 && d[7]) begin
      m_ctrl = 8'h40; m_drive = 0; m_go = 0;
      for (int i = 0; i < 8; i++) m_slot[i] = 0;
    end else if (a == 8'h01) m_ctrl = d & 8'h47;
    else if (a == 8'h02) m_drive = d;
    else if (a >= 8'h04 && a <= 8'h0B) m_slot[a - 8'h04] = d;
    else if (a == 8'h0C) m_go = {7'b0, d[0]};
  endtask

  task automatic bus_start();
    sda_m = 1; #(Q); scl_m = 1; #(Q); sda_m = 0; #(Q); scl_m = 0; #(Q);
  endtask
  task automatic bus_stop();
    sda_m = 0; #(Q); scl_m = 1; #(Q); sda_m = 1; #(Q);
  endtask
  task automatic send_bit(input bit b);
    sda_m = b; #(Q); scl_m = 1; #(2*Q); scl_m = 0; #(Q);
  endtask
  task automatic recv_bit(output bit b);
    sda_m = 1; #(Q); scl_m = 1; #(Q); b = sda_line; #(Q); scl_m = 0; #(Q);
  endtask
  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask
  task automatic recv_byte(input bit last, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(last);
  endtask

  // R2/R3: write frame with n bytes from pointer p
  task automatic write_regs(input logic [7:0] p, input logic [7:0] d [8], input int n, input string tag);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); check(ack, {tag, " R2 addr ack"}, {7'b0, ack}, 8'h01);
    send_byte(p, ack);           check(ack, {tag, " R2 ptr ack"}, {7'b0, ack}, 8'h01);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack);      check(ack, {tag, " R2 data ack"}, {7'b0, ack}, 8'h01);
      m_write(p + 8'(i), d[i]);
    end
    bus_stop();
    #(10*CLK_NS);
  endtask

  task automatic read_body(input logic [7:0] p, input int n, input string tag);
    bit ack;
    logic [7:0] v;
    send_byte({DEV, 1'b1}, ack); check(ack, {tag, " R4 rd addr ack"}, {7'b0, ack}, 8'h01);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(m_read(p + 8'(i)));
      tag_q.push_back(tag);
      recv_byte(i == n-1, v);
      act_q.push_back(v);
    end
    bus_stop();
    #(10*CLK_NS);
  endtask

  task automatic read_regs(input logic [7:0] p, input int n, input string tag);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); check(ack, {tag, " R2 addr ack"}, {7'b0, ack}, 8'h01);
    send_byte(p, ack);           check(ack, {tag, " R2 ptr ack"}, {7'b0, ack}, 8'h01);
    bus_start();
    read_body(p, n, tag);
  endtask

  task automatic read_cur(input logic [7:0] p, input int n, input string tag);
    bus_start();
    read_body(p, n, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        check(a == e, t, a, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * CLK_NS);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=00 expected=01");
    finish_run();
  end

  initial begin
    logic [7:0] d [8];
    bit ack;
    for (int i = 0; i < 8; i++) m_slot[i] = 0;
    #(2);
    #(5*CLK_NS); rst_n = 1'b1; #(5*CLK_NS);

    check(standby == 1 && mode == 0, "R6 reset ports", {standby, 4'b0, mode}, 8'h80);
    check(drive == 0, "R9 reset drive", drive, 8'h00);
    check(go == 0 && sda_oe == 0, "R10 reset go/sda", {6'b0, go, sda_oe}, 8'h00);

    read_regs(8'h00, 3, "R5 R6 R8 id/ctrl/drive in standby");

    // R1: foreign address
    bus_start();
    send_byte({7'h22, 1'b0}, ack);
    check(!ack, "R1 foreign addr nack", {7'b0, ack}, 8'h00);
    send_byte(8'h02, ack); send_byte(8'hAA, ack);
    bus_stop(); #(10*CLK_NS);
    read_regs(8'h02, 1, "R1 no write on foreign frame");

    // R3/R10: eight slots in one burst
    for (int i = 0; i < 8; i++) d[i] = 8'h11 * 8'(i + 1) ^ 8'h5C;
    write_regs(8'h04, d, 8, "R3 slot burst");
    read_regs(8'h04, 8, "R3 R4 R10 slot readback");
    read_cur(8'h0C, 2, "R4 resume at pointer");

    // R10 launch bit
    d[0] = 8'hFF; write_regs(8'h0C, d, 1, "R10 go");
    check(go == 1, "R10 go_o set", {7'b0, go}, 8'h01);
    read_regs(8'h0C, 1, "R10 go upper bits zero");

    // R11 unmapped
    d[0] = 8'h55; write_regs(8'h03, d, 1, "R11 unmapped 03");
    d[0] = 8'hAA; write_regs(8'hF0, d, 1, "R11 unmapped F0");
    read_regs(8'h03, 1, "R11 read 03");
    read_regs(8'hF0, 1, "R11 read F0");

    // R5 id write ignored
    d[0] = 8'h12; write_regs(8'h00, d, 1, "R5 id write");
    read_regs(8'h00, 1, "R5 id unchanged");

    // R9 direct drive
    d[0] = 8'h37; write_regs(8'h02, d, 1, "R9 drive value");
    check(drive == 0, "R9 drive gated by standby", drive, 8'h00);
    d[0] = 8'h3D; write_regs(8'h01, d, 1, "R6 ctrl write");
    check(mode == 3'd5 && standby == 0, "R6 ctrl ports", {standby, 4'b0, mode}, 8'h05);
    check(drive == 8'h37, "R9 drive passes", drive, 8'h37);
    read_regs(8'h01, 1, "R6 reserved bits zero");
    d[0] = 8'h45; write_regs(8'h01, d, 1, "R8 standby set");
    check(drive == 0 && standby == 1, "R8 R9 standby gates drive", drive, 8'h00);
    d[0] = 8'h77; write_regs(8'h02, d, 1, "R8 write in standby");
    read_regs(8'h02, 1, "R8 read in standby");

    // R3 across ctrl into drive
    d[0] = 8'h05; d[1] = 8'h9C; write_regs(8'h01, d, 2, "R3 cross ctrl");
    check(drive == 8'h9C, "R3 R9 drive after burst", drive, 8'h9C);

    // R7 soft reset
    d[0] = 8'h85; write_regs(8'h01, d, 1, "R7 soft reset");
    check(mode == 0 && standby == 1, "R7 ctrl defaults", {standby, 4'b0, mode}, 8'h80);
    check(drive == 0 && go == 0, "R7 outputs cleared", {drive[6:0], go}, 8'h00);
    read_regs(8'h00, 13, "R7 all defaults");

    // R12 aborted frame then valid write
    bus_start();
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    bus_start();
    send_byte({DEV, 1'b0}, ack); check(ack, "R12 addr ack after restart", {7'b0, ack}, 8'h01);
    send_byte(8'h05, ack);
    send_byte(8'hC3, ack); m_write(8'h05, 8'hC3);
    bus_stop(); #(10*CLK_NS);
    read_regs(8'h05, 1, "R12 write after restart");
    check(sda_oe == 0, "R12 idle after stop", {7'b0, sda_oe}, 8'h00);

    #(20*CLK_NS);
    finish_run();
  end
endmodule